// File: doc/BRIEF.md
# External Memory Strobe Sequencer

This block produces the timing strobes and port drive for the external memory interface of an 8-bit microcontroller. Every machine cycle is twelve oscillator clocks long. The block takes the fetch address and any pending external data request when the current cycle closes. For the next cycle it then generates three things:

- the address-latch strobe;
- the active-low code-read enable, or the active-low data read or data write strobe;
- the time-multiplexed low address/data byte and the high address byte.

A system places an external transparent latch on the low port and closes it on the falling edge of the address strobe. The strobe repeats at one sixth of the oscillator rate, so it can also serve as a free-running timing output. A suppression input silences it when no external traffic needs it. Bytes returned by external memory are captured at the end of each strobe and presented for one clock with a valid flag.

Top module: `xmem_strobe_seq`

## Requirements
- R1: While `rst` is high: `addr_stb` is 0; `code_oe_n`, `dat_rd_n` and `dat_wr_n` are 1; `lo_oe`, `code_vld` and `xrd_vld` are 0.
- R2: Clocks in a machine cycle are numbered 0 to 11. In a fetch cycle with the strobe enabled, `addr_stb` is high in clocks 0-1 and 6-7 and low otherwise, giving two 2-clock pulses per 12 clocks.
- R3: In a data cycle (`xreq` high when the previous cycle closed), `addr_stb` is high only in clocks 0-1. The second pulse is skipped.
- R4: In an internal fetch cycle with `ale_off` high and `code_rd` low, `addr_stb` stays low for the whole cycle. With `code_rd` high, both pulses appear.
- R5: `ale_off` has no effect on an external fetch cycle (both pulses appear) or on a data cycle (the first pulse appears).
- R6: In an external fetch cycle, `code_oe_n` is low in clocks 2-4 and 8-10. In an internal fetch cycle it stays high.
- R7: In a data cycle, `code_oe_n` stays high. `dat_rd_n` (read, `xwr`=0) or `dat_wr_n` (write, `xwr`=1) is low in clocks 6-10. The two are never low together.
- R8: A fetch is external when `force_ext` is high, for any address, or when `pc_addr` >= ROM_BYTES (4096). Otherwise it is internal.
- R9: The low port output is as follows:
  - In an external fetch, `lo_oe`=1 with `lo_out` = fetch address bits 7:0 in clocks 0-1, and address+1 bits 7:0 in clocks 6-7.
  - In a data cycle, `lo_oe`=1 with `lo_out` = `xaddr[7:0]` in clocks 0-1.
  - In a write, `lo_oe`=1 with `lo_out` = `xwdata` in clocks 2-11.
  - In every other clock `lo_oe`=0, including all read and code-enable windows.
- R10: `hi_out` carries the upper address byte in an external fetch (address in clocks 0-5, address+1 in clocks 6-11) and in a data cycle with `xwide`=1. Otherwise it carries `hi_latch`, as sampled when the cycle was set up.
- R11: In an external fetch, `lo_in` is captured at the clock edges that end clocks 4 and 10. The captured byte is shown on `code_byte` with `code_vld` high for clocks 5 and 11. In a read cycle, `lo_in` is captured at the edge ending clock 10 and shown on `xrd_data` with `xrd_vld` high in clock 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| force_ext | input | 1 | Take every fetch from external memory |
| pc_addr | input | 16 | Fetch address for the next cycle |
| xreq | input | 1 | Next cycle is an external data access |
| xwr | input | 1 | Data access is a write |
| xwide | input | 1 | Data access uses a 16-bit address |
| xaddr | input | 16 | Data access address |
| xwdata | input | 8 | Write data |
| ale_off | input | 1 | Suppress the address strobe when not needed |
| code_rd | input | 1 | Table read from code space in progress (strobe allowed) |
| hi_latch | input | 8 | High port latch value when no address is driven |
| lo_in | input | 8 | Low port pin value |
| addr_stb | output | 1 | Address-latch strobe, active high |
| code_oe_n | output | 1 | Code memory output enable, active low |
| dat_rd_n | output | 1 | Data memory read strobe, active low |
| dat_wr_n | output | 1 | Data memory write strobe, active low |
| lo_out | output | 8 | Low port drive value |
| lo_oe | output | 1 | Low port drive enable |
| hi_out | output | 8 | High port drive value |
| code_byte | output | 8 | Captured code byte |
| code_vld | output | 1 | Code byte valid |
| xrd_data | output | 8 | Captured read data |
| xrd_vld | output | 1 | Read data valid |

## Verification
The bench uses the default parameters: a 16-bit address, an 8-bit data path and a 4096-byte internal code space. These values put the internal/external split at an address the bench can reach directly. It fetches at 0x0FFF and 0x1000 to cover both sides of that split, and at 0x10FF so that the address+1 of the second code slot carries into the high byte. A small external memory on the low port answers code reads and data reads with values derived from the latched address.

// File: rtl/xmem_strobe_seq.sv
module xmem_strobe_seq #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ROM_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_ext,
  input  logic [AW-1:0]     pc_addr,
  input  logic              xreq,
  input  logic              xwr,
  input  logic              xwide,
  input  logic [AW-1:0]     xaddr,
  input  logic [DW-1:0]     xwdata,
  input  logic              ale_off,
  input  logic              code_rd,
  input  logic [AW-DW-1:0]  hi_latch,
  input  logic [DW-1:0]     lo_in,
  output logic              addr_stb,
  output logic              code_oe_n,
  output logic              dat_rd_n,
  output logic              dat_wr_n,
  output logic [DW-1:0]     lo_out,
  output logic              lo_oe,
  output logic [AW-DW-1:0]  hi_out,
  output logic [DW-1:0]     code_byte,
  output logic              code_vld,
  output logic [DW-1:0]     xrd_data,
  output logic              xrd_vld
);
  localparam int PW = 4;
  localparam logic [PW-1:0] LAST = 4'd11;
  localparam logic [AW:0]   ROM_LIM = (AW+1)'(ROM_BYTES);

  logic [PW-1:0]    ph;
  logic             c_data, c_wr, c_wide, c_ext, c_aleok;
  logic [AW-1:0]    c_addr;
  logic [DW-1:0]    c_wd;
  logic [AW-DW-1:0] c_hl;

  wire go_ext = !xreq && (force_ext || ({1'b0, pc_addr} >= ROM_LIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= LAST;
      c_data  <= 1'b0;
      c_wr    <= 1'b0;
      c_wide  <= 1'b0;
      c_ext   <= 1'b0;
      c_aleok <= 1'b0;
      c_addr  <= '0;
      c_wd    <= '0;
      c_hl    <= '0;
    end else begin
      ph <= (ph == LAST) ? '0 : ph + 4'd1;
      if (ph == LAST) begin
        c_data  <= xreq;
        c_wr    <= xwr;
        c_wide  <= xwide;
        c_ext   <= go_ext;
        c_aleok <= !ale_off || xreq || code_rd || go_ext;
        c_addr  <= xreq ? xaddr : pc_addr;
        c_wd    <= xwdata;
        c_hl    <= hi_latch;
      end
    end
  end

  wire slot_a   = ph < 4'd2;
  wire slot_b   = (ph == 4'd6) || (ph == 4'd7);
  wire half_b   = ph >= 4'd6;
  wire code_win = (ph >= 4'd2 && ph <= 4'd4) || (ph >= 4'd8 && ph <= 4'd10);
  wire strb_win = ph >= 4'd6 && ph <= 4'd10;
  wire wdrive   = c_data && c_wr && ph >= 4'd2;

  wire [AW-1:0] nxt = c_addr + 1'b1;
  wire [AW-1:0] cur = (c_ext && half_b) ? nxt : c_addr;

  assign addr_stb  = c_aleok && (slot_a || (slot_b && !c_data));
  assign code_oe_n = !(c_ext && code_win);
  assign dat_rd_n  = !(c_data && !c_wr && strb_win);
  assign dat_wr_n  = !(c_data && c_wr && strb_win);
  assign lo_oe     = wdrive || ((c_ext || c_data) && slot_a) || (c_ext && slot_b);
  assign lo_out    = wdrive ? c_wd : cur[DW-1:0];
  assign hi_out    = (c_ext || (c_data && c_wide)) ? cur[AW-1:DW] : c_hl;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_vld  <= 1'b0;
      xrd_vld   <= 1'b0;
      code_byte <= '0;
      xrd_data  <= '0;
    end else begin
      code_vld <= c_ext && (ph == 4'd4 || ph == 4'd10);
      xrd_vld  <= c_data && !c_wr && ph == 4'd10;
      if (c_ext && (ph == 4'd4 || ph == 4'd10)) code_byte <= lo_in;
      if (c_data && !c_wr && ph == 4'd10)       xrd_data  <= lo_in;
    end
  end
endmodule

// File: rtl/xmem_strobe_chk.sv
module xmem_strobe_chk (
  input logic clk,
  input logic rst,
  input logic addr_stb,
  input logic code_oe_n,
  input logic dat_rd_n,
  input logic dat_wr_n,
  input logic lo_oe,
  input logic code_vld,
  input logic xrd_vld
);
  // R2
  stb_width_lo_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_stb) |=> addr_stb);
  // R2
  stb_width_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_stb && $past(addr_stb)) |=> !addr_stb);
  // R6
  code_vs_stb_chk: assert property (@(posedge clk) disable iff (rst)
    !code_oe_n |-> !addr_stb);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!code_oe_n && (!dat_rd_n || !dat_wr_n)) && !(!dat_rd_n && !dat_wr_n));
  // R9
  rd_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!dat_rd_n || !code_oe_n) |-> !lo_oe);
  // R11
  code_cap_chk: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> $rose(code_oe_n));
  // R11
  rd_cap_chk: assert property (@(posedge clk) disable iff (rst)
    xrd_vld |-> $rose(dat_rd_n));
endmodule

bind xmem_strobe_seq xmem_strobe_chk u_chk (
  .clk(clk), .rst(rst), .addr_stb(addr_stb), .code_oe_n(code_oe_n),
  .dat_rd_n(dat_rd_n), .dat_wr_n(dat_wr_n), .lo_oe(lo_oe),
  .code_vld(code_vld), .xrd_vld(xrd_vld)
);

// File: tb/xmem_strobe_seq_test.sv
module xmem_strobe_seq_test;
  localparam int CLK_PER = 10;

  logic clk = 0, rst = 1;
  logic force_ext = 0, xreq = 0, xwr = 0, xwide = 0, ale_off = 0, code_rd = 0;
  logic [15:0] pc_addr = 0, xaddr = 0;
  logic [7:0] xwdata = 0, hi_latch = 8'hA5, lo_in, lat = 0;
  logic addr_stb, code_oe_n, dat_rd_n, dat_wr_n, lo_oe, code_vld, xrd_vld;
  logic [7:0] lo_out, hi_out, code_byte, xrd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  xmem_strobe_seq uut (
    .clk(clk), .rst(rst), .force_ext(force_ext), .pc_addr(pc_addr),
    .xreq(xreq), .xwr(xwr), .xwide(xwide), .xaddr(xaddr), .xwdata(xwdata),
    .ale_off(ale_off), .code_rd(code_rd), .hi_latch(hi_latch), .lo_in(lo_in),
    .addr_stb(addr_stb), .code_oe_n(code_oe_n), .dat_rd_n(dat_rd_n),
    .dat_wr_n(dat_wr_n), .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out),
    .code_byte(code_byte), .code_vld(code_vld), .xrd_data(xrd_data),
    .xrd_vld(xrd_vld)
  );

  always @(negedge clk) if (addr_stb) lat <= lo_out;
  assign lo_in = !code_oe_n ? (lat ^ 8'h5A) : !dat_rd_n ? (lat + 8'h33) : 8'h00;

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic run_cyc(string nm, logic fx, logic [15:0] pc, logic dq, logic wr,
                         logic wide, logic [15:0] xa, logic [7:0] wd,
                         logic off, logic mv);
    logic ext, aleok;
    logic [15:0] pn;
    force_ext = fx; pc_addr = pc; xreq = dq; xwr = wr; xwide = wide;
    xaddr = xa; xwdata = wd; ale_off = off; code_rd = mv;
    ext   = !dq && (fx || pc >= 16'd4096);
    aleok = !off || dq || mv || ext;
    pn    = pc + 16'd1;
    for (int p = 0; p < 12; p++) begin
      logic e_ale, e_code, e_rd, e_wr, e_oe;
      logic [7:0] e_lo, e_hi;
      string ra;
      @(posedge clk); @(negedge clk);
      e_ale  = aleok && (p < 2 || (!dq && (p == 6 || p == 7)));
      e_code = !(ext && ((p >= 2 && p <= 4) || (p >= 8 && p <= 10)));
      e_rd   = !(dq && !wr && p >= 6 && p <= 10);
      e_wr   = !(dq && wr && p >= 6 && p <= 10);
      e_oe   = (ext && (p < 2 || p == 6 || p == 7)) || (dq && p < 2) || (dq && wr && p >= 2);
      e_lo   = (dq && wr && p >= 2) ? wd : dq ? xa[7:0] : (p < 6 ? pc[7:0] : pn[7:0]);
      e_hi   = ext ? (p < 6 ? pc[15:8] : pn[15:8]) : (dq && wide) ? xa[15:8] : hi_latch;
      ra = dq ? "R3" : (off && !mv) ? (ext ? "R5" : "R4") : "R2";
      if (dq && off) ra = "R5";
      chk(ra, {nm, " addr_stb"}, {31'd0, addr_stb}, {31'd0, e_ale});
      chk(dq ? "R7" : fx ? "R8" : "R6", {nm, " code_oe_n"}, {31'd0, code_oe_n}, {31'd0, e_code});
      chk("R7", {nm, " rd/wr"}, {30'd0, dat_rd_n, dat_wr_n}, {30'd0, e_rd, e_wr});
      chk("R9", {nm, " lo_oe"}, {31'd0, lo_oe}, {31'd0, e_oe});
      if (e_oe) chk("R9", {nm, " lo_out"}, {24'd0, lo_out}, {24'd0, e_lo});
      chk("R10", {nm, " hi_out"}, {24'd0, hi_out}, {24'd0, e_hi});
      chk("R11", {nm, " code_vld"}, {31'd0, code_vld}, {31'd0, ext && (p == 5 || p == 11)});
      if (ext && p == 5)  chk("R11", {nm, " code_byte"}, {24'd0, code_byte}, {24'd0, pc[7:0] ^ 8'h5A});
      if (ext && p == 11) chk("R11", {nm, " code_byte"}, {24'd0, code_byte}, {24'd0, pn[7:0] ^ 8'h5A});
      chk("R11", {nm, " xrd_vld"}, {31'd0, xrd_vld}, {31'd0, dq && !wr && p == 11});
      if (dq && !wr && p == 11)
        chk("R11", {nm, " xrd_data"}, {24'd0, xrd_data}, {24'd0, xa[7:0] + 8'h33});
    end
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset strobes", {28'd0, addr_stb, code_oe_n, dat_rd_n, dat_wr_n}, 32'h7);
    chk("R1", "reset port/valid", {29'd0, lo_oe, code_vld, xrd_vld}, 32'h0);
    rst = 0;
  endtask

  task automatic t_internal_fetch;
    run_cyc("int 0123", 0, 16'h0123, 0, 0, 0, 0, 0, 0, 0);
    run_cyc("int 0FFF", 0, 16'h0FFF, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_external_fetch;
    run_cyc("ext 1000", 0, 16'h1000, 0, 0, 0, 0, 0, 0, 0);
    run_cyc("ext 10FF", 0, 16'h10FF, 0, 0, 0, 0, 0, 0, 0);
    run_cyc("forced 0010", 1, 16'h0010, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_data_cycles;
    run_cyc("rd16", 0, 16'h0200, 1, 0, 1, 16'h8177, 8'h00, 0, 0);
    run_cyc("wr8",  0, 16'h0200, 1, 1, 0, 16'h0042, 8'h3C, 0, 0);
    run_cyc("rd8",  1, 16'h0200, 1, 0, 0, 16'hFF10, 8'h00, 0, 0);
    run_cyc("wr16", 0, 16'h0200, 1, 1, 1, 16'hC3E9, 8'h96, 0, 0);
  endtask

  task automatic t_strobe_suppress;
    run_cyc("off int",     0, 16'h0040, 0, 0, 0, 0, 0, 1, 0);
    run_cyc("off int mv",  0, 16'h0041, 0, 0, 0, 0, 0, 1, 1);
    run_cyc("off ext",     0, 16'h2345, 0, 0, 0, 0, 0, 1, 0);
    run_cyc("off forced",  1, 16'h0042, 0, 0, 0, 0, 0, 1, 0);
    run_cyc("off rd",      0, 16'h0043, 1, 0, 1, 16'h5511, 0, 1, 0);
    run_cyc("off wr",      0, 16'h0044, 1, 1, 0, 16'h0033, 8'h7E, 1, 0);
    run_cyc("back on",     0, 16'h0045, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset;
    t_internal_fetch;
    t_external_fetch;
    t_data_cycles;
    t_strobe_suppress;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule